// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block sits in front of a cascaded pair of legacy interrupt controllers. It takes four shared, active-low PCI interrupt lines and places each one onto a legacy IRQ number chosen by software. Each line has its own 8-bit routing register, and the four registers occupy consecutive configuration offsets. The steered lines are OR-merged with sixteen active-high IRQ requests from legacy peripherals. The result is one sixteen-bit request vector.

A combinational lowest-number-wins encoder looks at the merged vector. It reports the winning IRQ index and a valid flag, and it drives a single INTR output toward the processor. Every routing entry comes out of reset disabled. An entry that holds a target the legacy side cannot accept is treated as disabled. The stored value is still returned on readback.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, every routing register reads 80h and no PCI line reaches `irq_out`, whatever the levels on `pci_int_n`.
- R2: Offsets 60h, 61h, 62h and 63h hold the routing registers of PCI lines A, B, C and D (`pci_int_n[0]` to `pci_int_n[3]`). A write is stored on the next clock edge, and a read returns the full 8-bit value last written.
- R3: In a routing register, bit 7 set means the entry is disabled and bits 3:0 give the target IRQ. Bits 6:4 are stored but have no effect on routing. An enabled entry with a legal target drives `irq_out[target]` high while its PCI line is low.
- R4: The legal targets are IRQ 1, 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. An entry whose target is 0, 2, 8 or 13 never drives any IRQ, but it still reads back unchanged.
- R5: `irq_out` is the bitwise OR of `isa_irq` and all steered PCI lines. Several sources on the same IRQ merge into one active-high request.
- R6: Reads from any offset outside 60h to 63h return 0. Writes to such offsets change no register and no output.
- R7: `irq_valid` is high exactly when `irq_out` is nonzero. `irq_id` then gives the lowest-numbered asserted bit of `irq_out`, and reads 0 when nothing is pending.
- R8: `intr` is high exactly when `irq_valid` is high.
- R9: A PCI line held high (deasserted) contributes nothing to `irq_out`, whatever its routing entry holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wr | input | 1 | Write strobe for `cfg_wdata` at `cfg_addr` |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| pci_int_n | input | 4 | PCI interrupt lines A..D, active low |
| isa_irq | input | 16 | Active-high legacy peripheral requests, one per IRQ |
| irq_out | output | 16 | Merged request vector toward the legacy controllers |
| irq_id | output | 4 | Index of the lowest-numbered pending IRQ |
| irq_valid | output | 1 | At least one IRQ is pending |
| intr | output | 1 | Interrupt request toward the processor |

## Verification
Steering and merging can fall in the same cycle. A PCI line can be steered onto an IRQ at the very moment a legacy peripheral or another PCI line asserts the same IRQ. The bench provokes this by routing three lines to one IRQ, with a fourth line on its own IRQ. It then sweeps all sixteen PCI level patterns against several legacy patterns, including ones that overlap the shared IRQ. Each merged vector, and the priority winner taken from it, is judged against an OR and a lowest-bit search that the bench computes from its own copy of the written register values.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int          LINES      = 4;
  localparam int          IRQS       = 16;
  localparam int          AW         = 8;
  localparam int          DW         = 8;
  localparam int          TGT_W      = 4;
  localparam int          DIS_BIT    = 7;
  localparam logic [7:0]  CFG_BASE   = 8'h60;
  localparam logic [7:0]  ENTRY_RST  = 8'h80;
  // legal targets: 1,3..7,9..12,14,15
  localparam logic [15:0] LEGAL_MASK = 16'hDEFA;
endpackage

// File: rtl/steer_regs.sv
module steer_regs
  import irq_steer_pkg::*;
#(
  parameter int            N_LINES = LINES,
  parameter int            A_W     = AW,
  parameter int            D_W     = DW,
  parameter logic [AW-1:0] BASE    = CFG_BASE,
  parameter logic [DW-1:0] RST_VAL = ENTRY_RST
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [A_W-1:0]         addr,
  input  logic                   wr,
  input  logic [D_W-1:0]         wdata,
  output logic [D_W-1:0]         rdata,
  output logic [N_LINES*D_W-1:0] regs_flat
);
  localparam int             IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [A_W-1:0] N_LINES_A = A_W'(N_LINES);

  logic [A_W-1:0]   off;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic [D_W-1:0]   regs_q [N_LINES];
  logic [D_W-1:0]   regs_d [N_LINES];

  always_comb begin
    off      = addr - BASE;
    in_range = (off < N_LINES_A);
    idx      = off[IDX_W-1:0];
    wr_en    = wr && in_range;
  end

  always_comb begin
    for (int k = 0; k < N_LINES; k++) regs_d[k] = regs_q[k];
    if (wr_en) regs_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_LINES; k++) regs_q[k] <= RST_VAL;
    end else if (wr_en) begin
      for (int k = 0; k < N_LINES; k++) regs_q[k] <= regs_d[k];
    end
  end

  always_comb begin
    rdata = in_range ? regs_q[idx] : '0;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_flat
    assign regs_flat[g*D_W +: D_W] = regs_q[g];

    // R2: a write to this entry's offset lands on the next edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == BASE + A_W'(g)) |=> (regs_q[g] == $past(wdata)));

    // R6: writes elsewhere (or no write) leave the entry alone
    assert_entry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == BASE + A_W'(g)) |=> $stable(regs_q[g]));
  end
endmodule

// File: rtl/steer_map.sv
module steer_map
  import irq_steer_pkg::*;
#(
  parameter int             N_LINES = LINES,
  parameter int             N_IRQ   = IRQS,
  parameter int             D_W     = DW,
  parameter int             T_W     = TGT_W,
  parameter int             OFF_BIT = DIS_BIT,
  parameter logic [IRQS-1:0] LEGAL  = LEGAL_MASK
) (
  input  logic [N_LINES*D_W-1:0] regs_flat,
  input  logic [N_LINES-1:0]     pci_int_n,
  input  logic [N_IRQ-1:0]       isa_irq,
  output logic [N_IRQ-1:0]       steered,
  output logic [N_IRQ-1:0]       irq_out
);
  logic [N_IRQ-1:0] line_vec [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [D_W-1:0] ent;
    logic [T_W-1:0] tgt;
    logic           live;
    always_comb begin
      ent  = regs_flat[g*D_W +: D_W];
      tgt  = ent[T_W-1:0];
      live = !ent[OFF_BIT] && LEGAL[tgt] && !pci_int_n[g];
      line_vec[g] = live ? (N_IRQ'(1) << tgt) : '0;
    end
  end

  always_comb begin
    steered = '0;
    for (int k = 0; k < N_LINES; k++) steered = steered | line_vec[k];
    irq_out = steered | isa_irq;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_IRQ = 16,
  parameter int ID_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req,
  output logic [ID_W-1:0]  id,
  output logic             valid
);
  always_comb begin
    id    = '0;
    valid = |req;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) id = ID_W'(i);
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_steer_pkg::*;
#(
  parameter int N_LINES = LINES,
  parameter int N_IRQ   = IRQS,
  parameter int ID_W    = $clog2(IRQS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cfg_addr,
  input  logic               cfg_wr,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      cfg_rdata,
  input  logic [N_LINES-1:0] pci_int_n,
  input  logic [N_IRQ-1:0]   isa_irq,
  output logic [N_IRQ-1:0]   irq_out,
  output logic [ID_W-1:0]    irq_id,
  output logic               irq_valid,
  output logic               intr
);
  logic [1:0]               sync_q;
  logic                     rst_sync_n;
  logic [N_LINES*DW-1:0]    regs_flat;
  logic [N_IRQ-1:0]         steered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  steer_regs #(.N_LINES(N_LINES), .A_W(AW), .D_W(DW),
               .BASE(CFG_BASE), .RST_VAL(ENTRY_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (cfg_addr),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .regs_flat(regs_flat)
  );

  steer_map #(.N_LINES(N_LINES), .N_IRQ(N_IRQ), .D_W(DW), .T_W(TGT_W),
              .OFF_BIT(DIS_BIT), .LEGAL(LEGAL_MASK)) u_map (
    .regs_flat(regs_flat),
    .pci_int_n(pci_int_n),
    .isa_irq  (isa_irq),
    .steered  (steered),
    .irq_out  (irq_out)
  );

  irq_prio #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_prio (
    .req  (irq_out),
    .id   (irq_id),
    .valid(irq_valid)
  );

  assign intr = irq_valid;

  // R4: steering never lands on an illegal IRQ
  assert_no_illegal_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (steered & ~LEGAL_MASK) == '0);

  // R5: legacy requests always survive the merge
  assert_isa_kept_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_out & isa_irq) == isa_irq);

  // R7: the reported winner is pending and nothing lower is
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid |-> (irq_out[irq_id] &&
                   ((irq_out & ((N_IRQ'(1) << irq_id) - N_IRQ'(1))) == '0)));

  // R8: processor request tracks any pending IRQ
  assert_intr_tracks_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    intr == (irq_out != '0));

  // R9: with all PCI lines high, nothing is steered
  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&pci_int_n) |-> (steered == '0));
endmodule

// File: tb/tb_pci_irq_router.sv
module tb_pci_irq_router;
  localparam logic [15:0] LEGAL = 16'hDEFA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pci_int_n;
  logic [15:0] isa_irq;
  logic [15:0] irq_out;
  logic [3:0]  irq_id;
  logic        irq_valid;
  logic        intr;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [4];

  always #2.5 clk = ~clk;

  pci_irq_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int_n(pci_int_n),
    .isa_irq(isa_irq), .irq_out(irq_out), .irq_id(irq_id),
    .irq_valid(irq_valid), .intr(intr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [3:0] pn, input logic [15:0] isa);
    logic [15:0] v;
    v = isa;
    for (int k = 0; k < 4; k++) begin
      if (!pn[k] && !model[k][7] && LEGAL[model[k][3:0]]) v[model[k][3:0]] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [3:0] exp_id(input logic [15:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 15; i >= 0; i--) if (v[i]) r = 4'(i);
    return r;
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) model[a - 8'h60] = d;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] e, input string req);
    cfg_addr = a;
    #1;
    check(cfg_rdata === e, req, 32'(cfg_rdata), 32'(e));
  endtask

  task automatic out_check(input string req);
    logic [15:0] e;
    #1;
    e = exp_vec(pci_int_n, isa_irq);
    check(irq_out === e, req, 32'(irq_out), 32'(e));
    check(irq_valid === (e != 0) && intr === (e != 0) && irq_id === exp_id(e),
          "R7/R8", {irq_valid, intr, 26'd0, irq_id}, {e != 0, e != 0, 26'd0, exp_id(e)});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_addr = 8'h00; cfg_wr = 1'b0; cfg_wdata = 8'h00;
    pci_int_n = 4'h0; isa_irq = 16'h0;
    for (int k = 0; k < 4; k++) model[k] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset defaults, all PCI lines asserted yet nothing steered
    for (int k = 0; k < 4; k++) rd_check(8'(8'h60 + k), 8'h80, "R1");
    #1;
    check(irq_out === 16'h0, "R1", 32'(irq_out), 32'h0);
    check(intr === 1'b0 && irq_valid === 1'b0 && irq_id === 4'd0, "R8",
          {intr, irq_valid, irq_id}, 32'h0);

    // R2/R3/R4/R9: per line, every target with and without disable
    for (int ln = 0; ln < 4; ln++) begin
      for (int v = 0; v < 32; v++) begin
        logic [7:0] val;
        val = 8'((v >= 16 ? 8'h80 : 8'h00) | (v % 16) | (ln == 2 ? 8'h70 : 8'h00));
        wr_reg(8'(8'h60 + ln), val);
        rd_check(8'(8'h60 + ln), val, "R2");
        pci_int_n = ~(4'b0001 << ln);
        out_check((v % 16 == 0 || v % 16 == 2 || v % 16 == 8 || v % 16 == 13) ? "R4" : "R3");
        pci_int_n = 4'hF;
        out_check("R9");
      end
      wr_reg(8'(8'h60 + ln), 8'h80);
    end

    // R5: three lines share IRQ 5, line C alone on IRQ 9
    wr_reg(8'h60, 8'h05);
    wr_reg(8'h61, 8'h05);
    wr_reg(8'h62, 8'h09);
    wr_reg(8'h63, 8'h05);
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 4; s++) begin
        logic [15:0] pat [4];
        pat[0] = 16'h0000; pat[1] = 16'h0020; pat[2] = 16'h8202; pat[3] = 16'h0008;
        @(negedge clk);
        pci_int_n = 4'(p);
        isa_irq = pat[s];
        out_check("R5");
      end
    end

    // R6: offsets outside the window read zero and ignore writes
    pci_int_n = 4'h0; isa_irq = 16'h0;
    foreach (model[k]) begin end
    begin
      logic [7:0] outside [5];
      outside[0] = 8'h5F; outside[1] = 8'h64; outside[2] = 8'h00;
      outside[3] = 8'hFF; outside[4] = 8'hE0;
      for (int i = 0; i < 5; i++) begin
        cfg_addr = outside[i]; cfg_wdata = 8'h83; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        rd_check(outside[i], 8'h00, "R6");
      end
      for (int k = 0; k < 4; k++) rd_check(8'(8'h60 + k), model[k], "R6");
      out_check("R6");
    end

    // R7/R8: exhaustive legacy pattern sweep with PCI idle
    for (int k = 0; k < 4; k++) wr_reg(8'(8'h60 + k), 8'h80);
    pci_int_n = 4'hF;
    for (int v = 0; v < 65536; v++) begin
      isa_irq = 16'(v);
      #1;
      check(irq_id === exp_id(16'(v)) && irq_valid === (v != 0), "R7",
            {27'd0, irq_valid, irq_id}, {27'd0, v != 0, exp_id(16'(v))});
      check(intr === (v != 0), "R8", 32'(intr), 32'(v != 0));
      #4;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule